// File: doc/BRIEF.md
# Aligned Sub-word Load/Store Unit

This unit sits between a register file and a memory port one word wide. It accepts one request at a time, either a load or a store, of either a half-word (the default sub-word width) or a full word. For every request it forms the word address by clearing the byte-offset bits. It starts the memory access in the same cycle that it checks alignment. A misaligned request is never split into smaller accesses. It raises a one-cycle fault instead.

On a load the unit waits for the memory read response. It steers the requested lane of the returned word to the result through a multiplexer, widens the result with zeros or sign copies, and presents it on a one-cycle valid strobe. The lane order is big-endian or little-endian, chosen by a parameter. On a sub-word store there are two cases. If the memory has per-lane write enables, the store data is copied into every lane and only the addressed lane's enable is raised. If the memory has no lane enables, the unit reads the containing word, splices the new lane in, and writes the whole word back. During that sequence it holds off new requests.

Top module: `subword_lsu`

## Requirements
- R1: The memory address equals the request address with its low log2(WORD_W/8) bits forced to zero. A load's read is issued in the same cycle the request is accepted, in parallel with the alignment check.
- R2: A half-word access is aligned only when address bit 0 is zero. A word access is aligned only when address bits 1:0 are zero. An accepted misaligned request drives `fault` high for exactly the cycle after acceptance. Aligned requests never raise it.
- R3: A misaligned request performs no memory write and produces no `ld_valid` strobe, and `ld_data` keeps its previous value.
- R4: Lane order. With BIG_END=1, a half-word at byte offset 0 (address bit 1 clear) comes from word bits 31:16, and offset 2 comes from bits 15:0. With BIG_END=0 the two are swapped.
- R5: A signed half-word load copies bit 15 of the selected half into result bits 31:16.
- R6: An unsigned half-word load returns zeros in result bits 31:16.
- R7: A word load returns the fetched word unchanged.
- R8: `ld_valid` pulses for one cycle, in the cycle right after `mem_rvalid`, with the result on `ld_data`.
- R9: With HAS_LANE_EN=0, a half-word store is carried out as one read of the containing word followed by one write of the whole word, with all `mem_be` bits high. Only the addressed half changes.
- R10: With HAS_LANE_EN=1, a half-word store is a single write in the acceptance cycle. `mem_be` is one-hot on the physical lane (bit i covers word bits 16i+15:16i), and `mem_wdata` carries the store half in both lanes.
- R11: `req_ready` is low from the acceptance of a load or of a read-modify-write store until that operation completes. Word stores and lane-enable stores leave it high.
- R12: A word store is a single write of all lanes in the acceptance cycle, with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request will be accepted |
| req_store | input | 1 | 1 = store, 0 = load |
| req_sub | input | 1 | 1 = sub-word access, 0 = full word |
| req_signed | input | 1 | Sign-extend a sub-word load |
| req_addr | input | AW | Byte address |
| req_wdata | input | WORD_W | Store data (sub-word in low bits) |
| mem_rd | output | 1 | Memory word read strobe |
| mem_wr | output | 1 | Memory word write strobe |
| mem_addr | output | AW | Word-aligned memory byte address |
| mem_be | output | WORD_W/SUB_W | Per-lane write enables |
| mem_wdata | output | WORD_W | Memory write data |
| mem_rdata | input | WORD_W | Memory read data |
| mem_rvalid | input | 1 | Read data valid |
| ld_valid | output | 1 | Load result strobe |
| ld_data | output | WORD_W | Load result |
| fault | output | 1 | Alignment fault pulse |

## Verification
The bench writes a word whose two halves have opposite sign bits. It then reads each half as signed and as unsigned, on a big-endian read-modify-write instance and on a little-endian lane-enable instance that share the same requests. A swapped lane order or a wrong extension shows up as a mismatched result. A half-word store is followed by a word load of the same address. A merge that corrupts the neighbouring half, or a write that skips the read, shows up as the wrong word. Misaligned loads and stores at each offset are sent; a design that wrote anyway, strobed `ld_valid` or changed `ld_data` is caught. The bench also counts reads and writes per request, which exposes a missing or extra memory access.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LD_WAIT = 2'd1,
        ST_RMW_RD  = 2'd2,
        ST_RMW_WR  = 2'd3
    } lsu_state_e;
endpackage

// File: rtl/lsu_align_chk.sv
// Alignment test and lane index from a byte address.
module lsu_align_chk #(
    parameter int AW     = 16,
    parameter int WORD_W = 32,
    parameter int SUB_W  = 16,
    localparam int NLANE = WORD_W / SUB_W,
    localparam int LW    = $clog2(NLANE)
) (
    input  logic [AW-1:0] addr,
    input  logic          is_sub,
    output logic          misaligned,
    output logic [LW-1:0] lane
);
    localparam int SOFF = $clog2(SUB_W / 8);
    localparam logic [AW-1:0] SMASK = AW'(SUB_W / 8 - 1);
    localparam logic [AW-1:0] WMASK = AW'(WORD_W / 8 - 1);

    always_comb begin
        misaligned = is_sub ? |(addr & SMASK) : |(addr & WMASK);
        lane       = LW'(addr >> SOFF);
    end
endmodule

// File: rtl/lsu_lane_pick.sv
// Steers one lane of a fetched word to the result and widens it.
module lsu_lane_pick #(
    parameter int WORD_W  = 32,
    parameter int SUB_W   = 16,
    parameter bit BIG_END = 1'b1,
    localparam int NLANE  = WORD_W / SUB_W,
    localparam int LW     = $clog2(NLANE)
) (
    input  logic [WORD_W-1:0] word,
    input  logic [LW-1:0]     lane,
    input  logic              sgn,
    output logic [WORD_W-1:0] ext
);
    logic [SUB_W-1:0] lanes [NLANE];
    logic [LW-1:0]    phys;
    logic [SUB_W-1:0] picked;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign lanes[g] = word[g*SUB_W +: SUB_W];
    end

    if (BIG_END) begin : g_be
        assign phys = ~lane;
    end else begin : g_le
        assign phys = lane;
    end

    always_comb begin
        picked = lanes[phys];
        ext    = {{(WORD_W-SUB_W){sgn & picked[SUB_W-1]}}, picked};
    end
endmodule

// File: rtl/lsu_lane_merge.sv
// Replicates store data, builds the one-hot lane enable and the merged word.
module lsu_lane_merge #(
    parameter int WORD_W  = 32,
    parameter int SUB_W   = 16,
    parameter bit BIG_END = 1'b1,
    localparam int NLANE  = WORD_W / SUB_W,
    localparam int LW     = $clog2(NLANE)
) (
    input  logic [LW-1:0]     lane,
    input  logic [SUB_W-1:0]  sdata,
    input  logic [WORD_W-1:0] old_word,
    output logic [WORD_W-1:0] rep_word,
    output logic [NLANE-1:0]  lane_be,
    output logic [WORD_W-1:0] merged
);
    logic [LW-1:0] phys;

    if (BIG_END) begin : g_be
        assign phys = ~lane;
    end else begin : g_le
        assign phys = lane;
    end

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign lane_be[g] = (phys == LW'(g));
        assign rep_word[g*SUB_W +: SUB_W] = sdata;
        assign merged[g*SUB_W +: SUB_W] =
            lane_be[g] ? sdata : old_word[g*SUB_W +: SUB_W];
    end
endmodule

// File: rtl/subword_lsu.sv
module subword_lsu #(
    parameter int AW          = 16,
    parameter int WORD_W      = 32,
    parameter int SUB_W       = 16,
    parameter bit BIG_END     = 1'b1,
    parameter bit HAS_LANE_EN = 1'b0,
    localparam int NLANE      = WORD_W / SUB_W,
    localparam int LW         = $clog2(NLANE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_store,
    input  logic              req_sub,
    input  logic              req_signed,
    input  logic [AW-1:0]     req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [AW-1:0]     mem_addr,
    output logic [NLANE-1:0]  mem_be,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_rvalid,
    output logic              ld_valid,
    output logic [WORD_W-1:0] ld_data,
    output logic              fault
);
    import lsu_pkg::*;

    localparam logic [AW-1:0] WMASK = AW'(WORD_W / 8 - 1);

    typedef struct packed {
        lsu_state_e        st;
        logic [AW-1:0]     addr;
        logic              sub;
        logic              sgn;
        logic              drop;
        logic [SUB_W-1:0]  sdata;
        logic [WORD_W-1:0] merged;
        logic              ld_valid;
        logic [WORD_W-1:0] ld_data;
        logic              fault;
    } regs_t;

    regs_t r_d, r_q;

    logic              idle;
    logic              accept;
    logic [AW-1:0]     sel_addr;
    logic              sel_sub;
    logic              mis;
    logic [LW-1:0]     lane;
    logic [SUB_W-1:0]  sel_sdata;
    logic [WORD_W-1:0] picked_ext;
    logic [WORD_W-1:0] rep_word;
    logic [NLANE-1:0]  lane_be;
    logic [WORD_W-1:0] merged;

    assign idle      = (r_q.st == ST_IDLE);
    assign accept    = req_valid && idle;
    assign sel_addr  = idle ? req_addr : r_q.addr;
    assign sel_sub   = idle ? req_sub : r_q.sub;
    assign sel_sdata = idle ? req_wdata[SUB_W-1:0] : r_q.sdata;

    lsu_align_chk #(.AW(AW), .WORD_W(WORD_W), .SUB_W(SUB_W)) u_align (
        .addr(sel_addr), .is_sub(sel_sub), .misaligned(mis), .lane(lane)
    );

    lsu_lane_pick #(.WORD_W(WORD_W), .SUB_W(SUB_W), .BIG_END(BIG_END)) u_pick (
        .word(mem_rdata), .lane(lane), .sgn(r_q.sgn), .ext(picked_ext)
    );

    lsu_lane_merge #(.WORD_W(WORD_W), .SUB_W(SUB_W), .BIG_END(BIG_END)) u_merge (
        .lane(lane), .sdata(sel_sdata), .old_word(mem_rdata),
        .rep_word(rep_word), .lane_be(lane_be), .merged(merged)
    );

    // Next-state computation.
    always_comb begin
        r_d          = r_q;
        r_d.ld_valid = 1'b0;
        r_d.fault    = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    r_d.addr  = req_addr;
                    r_d.sub   = req_sub;
                    r_d.sgn   = req_signed;
                    r_d.sdata = req_wdata[SUB_W-1:0];
                    r_d.fault = mis;
                    r_d.drop  = mis;
                    if (!req_store) begin
                        r_d.st = ST_LD_WAIT;
                    end else if (!mis && req_sub && !HAS_LANE_EN) begin
                        r_d.st = ST_RMW_RD;
                    end
                end
            end
            ST_LD_WAIT: begin
                if (mem_rvalid) begin
                    r_d.st = ST_IDLE;
                    if (!r_q.drop) begin
                        r_d.ld_valid = 1'b1;
                        r_d.ld_data  = r_q.sub ? picked_ext : mem_rdata;
                    end
                end
            end
            ST_RMW_RD: begin
                if (mem_rvalid) begin
                    r_d.merged = merged;
                    r_d.st     = ST_RMW_WR;
                end
            end
            ST_RMW_WR: begin
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    // Memory port drive.
    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = sel_addr & ~WMASK;
        mem_be    = '1;
        mem_wdata = r_q.merged;
        if (idle) begin
            mem_rd    = accept && (!req_store || (req_sub && !HAS_LANE_EN && !mis));
            mem_wr    = accept && req_store && !mis && (!req_sub || HAS_LANE_EN);
            mem_be    = req_sub ? lane_be : '1;
            mem_wdata = req_sub ? rep_word : req_wdata;
        end else if (r_q.st == ST_RMW_WR) begin
            mem_wr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = idle;
    assign ld_valid  = r_q.ld_valid;
    assign ld_data   = r_q.ld_data;
    assign fault     = r_q.fault;
endmodule

// File: rtl/lsu_checker.sv
module lsu_checker #(
    parameter int AW          = 16,
    parameter int WORD_W      = 32,
    parameter int SUB_W       = 16,
    parameter bit HAS_LANE_EN = 1'b0,
    localparam int NLANE      = WORD_W / SUB_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_sub,
    input logic [AW-1:0]     req_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [AW-1:0]     mem_addr,
    input logic [NLANE-1:0]  mem_be,
    input logic              mem_rvalid,
    input logic              ld_valid,
    input logic [WORD_W-1:0] ld_data,
    input logic              fault
);
    localparam logic [AW-1:0] WM = AW'(WORD_W / 8 - 1);
    localparam logic [AW-1:0] SM = AW'(SUB_W / 8 - 1);

    logic req_mis;
    assign req_mis = req_sub ? |(req_addr & SM) : |(req_addr & WM);

    p_word_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> ((mem_addr & WM) == '0));

    p_fault_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $past(req_valid && req_ready));

    p_mis_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_mis) |-> !mem_wr);

    p_ld_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |-> $stable(ld_data));

    p_ld_after_rvalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(mem_rvalid));

    p_rd_wr_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_full_be_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !HAS_LANE_EN) |-> (&mem_be));

    p_busy_no_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> !mem_rd);
endmodule

bind subword_lsu lsu_checker #(
    .AW(AW), .WORD_W(WORD_W), .SUB_W(SUB_W), .HAS_LANE_EN(HAS_LANE_EN)
) u_chk (.*);

// File: tb/sim_subword_lsu.sv
module sim_subword_lsu;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        req_valid = 1'b0, req_store = 1'b0, req_sub = 1'b0, req_signed = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;

    logic        u0_ready, u0_rd, u0_wr, u0_ldv, u0_fault;
    logic [15:0] u0_maddr;
    logic [1:0]  u0_be;
    logic [31:0] u0_wdata, u0_ld;
    logic        u1_ready, u1_rd, u1_wr, u1_ldv, u1_fault;
    logic [15:0] u1_maddr;
    logic [1:0]  u1_be;
    logic [31:0] u1_wdata, u1_ld;

    logic [31:0] mem [16];
    logic [31:0] shadow [16];
    logic        rv1, rvalid;
    logic [31:0] rd1, rdata;
    int rd_cnt = 0, wr_cnt = 0, cyc = 0, rv_cyc = 0;
    logic [15:0] last_rd_addr;
    int checks = 0, errors = 0;
    logic [31:0] q0[$], q1[$];

    subword_lsu u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(u0_ready),
        .req_store(req_store), .req_sub(req_sub), .req_signed(req_signed),
        .req_addr(req_addr), .req_wdata(req_wdata), .mem_rd(u0_rd), .mem_wr(u0_wr),
        .mem_addr(u0_maddr), .mem_be(u0_be), .mem_wdata(u0_wdata), .mem_rdata(rdata),
        .mem_rvalid(rvalid), .ld_valid(u0_ldv), .ld_data(u0_ld), .fault(u0_fault));

    subword_lsu #(.BIG_END(1'b0), .HAS_LANE_EN(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(u1_ready),
        .req_store(req_store), .req_sub(req_sub), .req_signed(req_signed),
        .req_addr(req_addr), .req_wdata(req_wdata), .mem_rd(u1_rd), .mem_wr(u1_wr),
        .mem_addr(u1_maddr), .mem_be(u1_be), .mem_wdata(u1_wdata), .mem_rdata(rdata),
        .mem_rvalid(rvalid), .ld_valid(u1_ldv), .ld_data(u1_ld), .fault(u1_fault));

    function automatic logic [31:0] init_word(input int i);
        return 32'h8A5C_3E71 ^ (32'(i) * 32'h1357_9BDF);
    endfunction

    function automatic logic [31:0] widen(input logic sgn, input logic [15:0] h);
        return sgn ? {{16{h[15]}}, h} : {16'h0, h};
    endfunction

    // Memory model for u0 only; u1 observes the same read responses.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= init_word(i);
            rv1 <= 1'b0; rvalid <= 1'b0; rd1 <= '0; rdata <= '0;
        end else begin
            if (u0_wr) begin
                for (int b = 0; b < 2; b++)
                    if (u0_be[b]) mem[u0_maddr[5:2]][b*16 +: 16] <= u0_wdata[b*16 +: 16];
                wr_cnt <= wr_cnt + 1;
            end
            if (u0_rd) begin
                rd_cnt <= rd_cnt + 1;
                last_rd_addr <= u0_maddr;
            end
            rv1 <= u0_rd; rd1 <= mem[u0_maddr[5:2]];
            rvalid <= rv1; rdata <= rd1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard when a load result appears.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rvalid) rv_cyc = cyc;
            if (u0_ldv) begin
                chk(cyc == rv_cyc + 1, "R8 u0 ld timing", 32'(cyc), 32'(rv_cyc + 1));
                if (q0.size() == 0) chk(1'b0, "R3 u0 unexpected ld_valid", u0_ld, 32'h0);
                else begin
                    logic [31:0] e0;
                    e0 = q0.pop_front();
                    chk(u0_ld == e0, "R4/R5/R6/R7 u0 load data", u0_ld, e0);
                end
            end
            if (u1_ldv) begin
                if (q1.size() == 0) chk(1'b0, "R3 u1 unexpected ld_valid", u1_ld, 32'h0);
                else begin
                    logic [31:0] e1;
                    e1 = q1.pop_front();
                    chk(u1_ld == e1, "R4/R5/R6/R7 u1 load data", u1_ld, e1);
                end
            end
        end
    end

    // Driver: issues one request, predicts and checks its side effects.
    task automatic do_req(input bit st, input bit sub, input bit sgn,
                          input logic [15:0] addr, input logic [31:0] wd);
        logic mis, k;
        logic [3:0] idx;
        logic [31:0] w, ld0_before;
        int rd0, wr0;
        while (!u0_ready || !u1_ready) @(negedge clk);
        mis = sub ? addr[0] : |addr[1:0];
        k   = addr[1];
        idx = addr[5:2];
        w   = shadow[idx];
        rd0 = rd_cnt; wr0 = wr_cnt; ld0_before = u0_ld;
        req_valid = 1'b1; req_store = st; req_sub = sub; req_signed = sgn;
        req_addr = addr; req_wdata = wd;
        if (!st && !mis) begin
            q0.push_back(sub ? widen(sgn, k ? w[15:0] : w[31:16]) : w);
            q1.push_back(sub ? widen(sgn, k ? w[31:16] : w[15:0]) : w);
        end
        #1;
        if (st && sub && !mis) begin
            chk(u1_wr == 1'b1, "R10 lane-enable write strobe", 32'(u1_wr), 32'h1);
            chk(u1_be == (k ? 2'b10 : 2'b01), "R10 one-hot lane enable",
                32'(u1_be), k ? 32'h2 : 32'h1);
            chk(u1_wdata == {wd[15:0], wd[15:0]}, "R10 replicated data",
                u1_wdata, {wd[15:0], wd[15:0]});
        end
        if (st && mis) chk(u1_wr == 1'b0, "R3 no write on misaligned (u1)", 32'(u1_wr), 32'h0);
        if (st && !mis) begin
            if (sub) w = k ? {w[31:16], wd[15:0]} : {wd[15:0], w[15:0]};
            else     w = wd;
            shadow[idx] = w;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(u0_fault == mis, "R2 fault u0", 32'(u0_fault), 32'(mis));
        chk(u1_fault == mis, "R2 fault u1", 32'(u1_fault), 32'(mis));
        chk(u0_ready == (st && !(sub && !mis)), "R11 ready u0 after accept",
            32'(u0_ready), 32'(st && !(sub && !mis)));
        chk(u1_ready == st, "R11 ready u1 after accept", 32'(u1_ready), 32'(st));
        while (!u0_ready || !u1_ready) @(negedge clk);
        @(negedge clk);
        if (!st) begin
            chk(rd_cnt - rd0 == 1, "R1 one read per load", 32'(rd_cnt - rd0), 32'h1);
            chk(last_rd_addr == (addr & ~16'h3), "R1 word address",
                32'(last_rd_addr), 32'(addr & ~16'h3));
            chk(wr_cnt == wr0, "R3 no write on load", 32'(wr_cnt - wr0), 32'h0);
            if (mis) chk(u0_ld == ld0_before, "R3 ld_data unchanged", u0_ld, ld0_before);
        end else begin
            chk(wr_cnt - wr0 == (mis ? 0 : 1), mis ? "R3 no write on misaligned" :
                "R9/R12 one write per store", 32'(wr_cnt - wr0), mis ? 32'h0 : 32'h1);
            chk(rd_cnt - rd0 == ((sub && !mis) ? 1 : 0), sub ? "R9 read before merge" :
                "R12 no read on word store", 32'(rd_cnt - rd0), (sub && !mis) ? 32'h1 : 32'h0);
            chk(mem[idx] == shadow[idx], "R9/R12 memory word", mem[idx], shadow[idx]);
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) shadow[i] = init_word(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(u0_ready == 1'b1, "R11 reset ready", 32'(u0_ready), 32'h1);
        chk(u0_ldv == 1'b0 && u0_fault == 1'b0, "R2 reset outputs quiet",
            32'({u0_ldv, u0_fault}), 32'h0);
        chk(u0_ld == 32'h0, "R3 reset ld_data", u0_ld, 32'h0);

        do_req(0, 0, 0, 16'h0004, 0);             // R7 word load
        do_req(0, 1, 1, 16'h0008, 0);             // R4 R5 initial data
        do_req(0, 1, 0, 16'h000A, 0);             // R6
        do_req(1, 0, 0, 16'h0010, 32'h8001_7FFE); // R12
        do_req(0, 1, 1, 16'h0010, 0);             // R4 R5: opposite signs per lane
        do_req(0, 1, 1, 16'h0012, 0);
        do_req(0, 1, 0, 16'h0010, 0);             // R6
        do_req(0, 1, 0, 16'h0012, 0);
        do_req(1, 1, 0, 16'h0012, 32'h1234_ABCD); // R9 R10
        do_req(0, 0, 0, 16'h0010, 0);             // R9 merged word
        do_req(1, 1, 0, 16'h0014, 32'h0000_5A5A);
        do_req(0, 0, 0, 16'h0014, 0);
        do_req(0, 0, 0, 16'h0006, 0);             // R2 R3 misaligned word load
        do_req(0, 1, 1, 16'h0011, 0);             // misaligned half load
        do_req(1, 0, 0, 16'h0013, 32'hDEAD_BEEF); // misaligned word store
        do_req(1, 1, 0, 16'h0015, 32'h0000_FFFF); // misaligned half store
        do_req(0, 0, 0, 16'h0014, 0);
        do_req(1, 0, 0, 16'h0020, 32'hFFFF_0001); // back-to-back word stores
        do_req(1, 0, 0, 16'h0024, 32'h0000_8000);
        do_req(0, 1, 1, 16'h0022, 0);
        do_req(0, 1, 1, 16'h0026, 0);
        repeat (4) @(negedge clk);
        chk(q0.size() == 0 && q1.size() == 0, "R8 all loads returned",
            32'(q0.size() + q1.size()), 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "R8 watchdog expired", 32'h0, 32'h1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule